// File: doc/BRIEF.md
# Interrupt Vector Table with Pending Array

This block keeps a table of interrupt message descriptors in a memory-mapped window and turns indexed interrupt requests into messages. Each descriptor is 16 bytes long and holds four 32-bit words: a low address word, a high address word, a data word and a control word. Bit 0 of the control word masks the descriptor. A read-only pending region follows the table in the same window. It begins at the table size rounded up to a 4096-byte boundary and always reads as zero.

Software reaches the window through a single access port. Each access is a 4-byte or 8-byte read or write, and any other access is treated as unserviceable. An 8-byte access covers two neighbouring words in one cycle. Interrupt sources present an index on a request port. The block emits a destination/vector message one cycle later, but only when the configuration inputs and the descriptor's own mask allow it. A request that cannot be delivered is discarded.

Top module: `irq_vector_table`

## Requirements
- R1: An access at byte offset `off` targets descriptor `off/16`. Within a descriptor, the words at offsets 0, 4, 8 and 12 are low address, high address, data and control. A 4-byte write stores `wdata[31:0]` into the addressed word, and a later 4-byte read of that word returns it.
- R2: An access whose byte count is neither 4 nor 8 changes nothing, and a read of that kind returns all ones.
- R3: An access whose offset within the descriptor is not a multiple of its byte count changes nothing, and a read of that kind returns all ones.
- R4: A write to a descriptor index at or above ENTRIES is dropped. A read there, outside the pending region, returns all ones.
- R5: Aligned 4- or 8-byte reads return zero inside the pending region. That region starts at `ceil(ENTRIES*16/4096)*4096` and is `((ENTRIES-1)/64+1)*8` bytes long. Writes there leave it at zero, and a read just past its end returns all ones.
- R6: After reset, the control word of every descriptor reads as 32'h0000_0001 (masked).
- R7: An 8-byte access at descriptor offset 0 or 8 covers two words. The word at the lower offset sits in bits [31:0], the next word sits in bits [63:32], and both are read or written in the same cycle.
- R8: A read accepted on one clock edge produces `rd_valid` with its data on the next edge. A 4-byte read returns its word in bits [31:0], with bits [63:32] zero.
- R9: A request produces a message only if all of the following hold: `cfg_enable` is 1, `cfg_legacy_en` is 0, `cfg_func_mask` is 0, the index is below ENTRIES, and control bit 0 of the indexed descriptor is 0.
- R10: A permitted request raises `msg_valid` on the next edge. `msg_dest` then equals bits [19:12] of the low address word and `msg_vector` equals bits [7:0] of the data word.
- R11: A blocked request is discarded. Unmasking its descriptor later produces no message, and the pending region still reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_bytes | input | 4 | Access byte count (only 4 and 8 serviced) |
| acc_offset | input | OFF_W | Byte offset in the window |
| acc_wdata | input | 64 | Write data, lower word in [31:0] |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |
| cfg_enable | input | 1 | Table delivery enabled |
| cfg_legacy_en | input | 1 | Single-message scheme active (blocks delivery) |
| cfg_func_mask | input | 1 | Whole-function mask |
| irq_req | input | 1 | Interrupt request |
| irq_index | input | IRQ_W | Requested descriptor index |
| msg_valid | output | 1 | Message emitted |
| msg_dest | output | 8 | Message destination |
| msg_vector | output | 8 | Message vector |

## Verification
The bench goes after access legality at its edges. It checks 1- and 2-byte accesses, an 8-byte access at offset 4, and a 4-byte access at offset 2. A design that tested only size, or only alignment, would corrupt a neighbouring word or return stale data instead of all ones. It reads the first and last bytes of the pending region and the bytes just outside it. An off-by-one window would return zero where all ones belong, or the reverse. It walks each delivery gate on its own and re-checks a blocked request after unmasking. A design that queued blocked requests would then emit a late message. A behavioural model also compares every cycle while inputs are randomised.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

  typedef enum logic [1:0] {
    RK_NONE  = 2'd0,
    RK_TABLE = 2'd1,
    RK_PEND  = 2'd2,
    RK_BAD   = 2'd3
  } rd_kind_e;

  // First byte of the pending region: table bytes rounded up to 4 KiB.
  function automatic int unsigned pend_base(input int unsigned n);
    return ((n * 16 + 4095) / 4096) * 4096;
  endfunction

  // Pending region length in bytes: one 64-bit word per 64 descriptors.
  function automatic int unsigned pend_bytes(input int unsigned n);
    return ((n - 1) / 64 + 1) * 8;
  endfunction

endpackage

// File: rtl/ivt_decode.sv
module ivt_decode
  import ivt_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned OFF_W   = 14,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned PB     = pend_base(ENTRIES),
  localparam int unsigned PS     = pend_bytes(ENTRIES)
) (
  input  logic [OFF_W-1:0] offset,
  input  logic [3:0]       bytes,
  output logic             hit_table,
  output logic             hit_pend,
  output logic             wide,
  output logic [IDX_W-1:0] idx,
  output logic [1:0]       word
);
  logic             size_ok;
  logic             aligned;
  logic [OFF_W-5:0] ent;

  assign size_ok   = (bytes == 4'd4) || (bytes == 4'd8);
  assign aligned   = bytes[3] ? (offset[2:0] == 3'b000) : (offset[1:0] == 2'b00);
  assign ent       = offset[OFF_W-1:4];
  assign hit_table = size_ok && aligned && (32'(ent) < ENTRIES);
  assign hit_pend  = size_ok && aligned && !hit_table &&
                     (32'(offset) >= PB) && (32'(offset) < PB + PS);
  assign wide      = bytes[3];
  assign idx       = ent[IDX_W-1:0];
  assign word      = offset[3:2];
endmodule

// File: rtl/ivt_store.sv
module ivt_store #(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [IDX_W-1:0]   idx,
  input  logic [1:0]         word,
  input  logic               wide,
  input  logic [63:0]        wdata,
  output logic [31:0]        q_alo,
  output logic [31:0]        q_ahi,
  output logic [31:0]        q_dat,
  output logic [31:0]        q_vc,
  output logic [ENTRIES*8-1:0] dest_flat,
  output logic [ENTRIES*8-1:0] vec_flat,
  output logic [ENTRIES-1:0]   mask_flat
);
  // Address and data words: plain arrays, no reset, block-RAM friendly.
  logic [31:0] mem_alo [ENTRIES];
  logic [31:0] mem_ahi [ENTRIES];
  logic [31:0] mem_dat [ENTRIES];
  logic [31:0] vc_arr  [ENTRIES];

  logic        we_alo, we_ahi, we_dat, we_vc;
  logic [31:0] hi_wd;

  assign we_alo = (word == 2'd0);
  assign we_ahi = wide ? (word == 2'd0) : (word == 2'd1);
  assign we_dat = (word == 2'd2);
  assign we_vc  = wide ? (word == 2'd2) : (word == 2'd3);
  assign hi_wd  = wide ? wdata[63:32] : wdata[31:0];

  always_ff @(posedge clk) begin
    if (wr_en && we_alo) mem_alo[idx] <= wdata[31:0];
    if (wr_en && we_ahi) mem_ahi[idx] <= hi_wd;
    if (wr_en && we_dat) mem_dat[idx] <= wdata[31:0];
    if (rd_en) begin
      q_alo <= mem_alo[idx];
      q_ahi <= mem_ahi[idx];
      q_dat <= mem_dat[idx];
      q_vc  <= vc_arr[idx];
    end
  end

  // Control word and the delivery fields live in flops so reset applies.
  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic [31:0] vc_r;
    logic [7:0]  dest_r;
    logic [7:0]  vec_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        vc_r   <= 32'd1;
        dest_r <= 8'd0;
        vec_r  <= 8'd0;
      end else if (wr_en && idx == IDX_W'(e)) begin
        if (we_vc)  vc_r   <= hi_wd;
        if (we_alo) dest_r <= wdata[19:12];
        if (we_dat) vec_r  <= wdata[7:0];
      end
    end
    assign vc_arr[e]          = vc_r;
    assign mask_flat[e]       = vc_r[0];
    assign dest_flat[e*8 +: 8] = dest_r;
    assign vec_flat[e*8 +: 8]  = vec_r;
  end
endmodule

// File: rtl/ivt_deliver.sv
module ivt_deliver #(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned IRQ_W  = IDX_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req,
  input  logic [IRQ_W-1:0]     index,
  input  logic                 en,
  input  logic                 legacy,
  input  logic                 fmask,
  input  logic [ENTRIES*8-1:0] dest_flat,
  input  logic [ENTRIES*8-1:0] vec_flat,
  input  logic [ENTRIES-1:0]   mask_flat,
  output logic                 msg_valid,
  output logic [7:0]           msg_dest,
  output logic [7:0]           msg_vector
);
  logic [IDX_W-1:0] sel;
  logic             in_range;
  logic             permit;

  assign sel      = index[IDX_W-1:0];
  assign in_range = 32'(index) < ENTRIES;
  assign permit   = req && en && !legacy && !fmask && in_range && !mask_flat[sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid  <= 1'b0;
      msg_dest   <= 8'd0;
      msg_vector <= 8'd0;
    end else begin
      msg_valid <= permit;
      if (permit) begin
        msg_dest   <= dest_flat[sel*8 +: 8];
        msg_vector <= vec_flat[sel*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/irq_vector_table.sv
module irq_vector_table
  import ivt_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned OFF_W  = $clog2(pend_base(ENTRIES) + pend_bytes(ENTRIES)) + 1,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned IRQ_W  = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [3:0]       acc_bytes,
  input  logic [OFF_W-1:0] acc_offset,
  input  logic [63:0]      acc_wdata,
  output logic             rd_valid,
  output logic [63:0]      rd_data,
  input  logic             cfg_enable,
  input  logic             cfg_legacy_en,
  input  logic             cfg_func_mask,
  input  logic             irq_req,
  input  logic [IRQ_W-1:0] irq_index,
  output logic             msg_valid,
  output logic [7:0]       msg_dest,
  output logic [7:0]       msg_vector
);
  logic             hit_table, hit_pend, wide;
  logic [IDX_W-1:0] idx;
  logic [1:0]       word;

  ivt_decode #(.ENTRIES(ENTRIES), .OFF_W(OFF_W)) u_dec (
    .offset(acc_offset), .bytes(acc_bytes), .hit_table(hit_table),
    .hit_pend(hit_pend), .wide(wide), .idx(idx), .word(word)
  );

  logic [31:0]          q_alo, q_ahi, q_dat, q_vc;
  logic [ENTRIES*8-1:0] dest_flat, vec_flat;
  logic [ENTRIES-1:0]   mask_flat;

  ivt_store #(.ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(acc_valid && acc_write && hit_table),
    .rd_en(acc_valid && !acc_write && hit_table),
    .idx(idx), .word(word), .wide(wide), .wdata(acc_wdata),
    .q_alo(q_alo), .q_ahi(q_ahi), .q_dat(q_dat), .q_vc(q_vc),
    .dest_flat(dest_flat), .vec_flat(vec_flat), .mask_flat(mask_flat)
  );

  ivt_deliver #(.ENTRIES(ENTRIES)) u_dlv (
    .clk(clk), .rst(rst), .req(irq_req), .index(irq_index),
    .en(cfg_enable), .legacy(cfg_legacy_en), .fmask(cfg_func_mask),
    .dest_flat(dest_flat), .vec_flat(vec_flat), .mask_flat(mask_flat),
    .msg_valid(msg_valid), .msg_dest(msg_dest), .msg_vector(msg_vector)
  );

  // Read response bookkeeping, one cycle behind the access.
  rd_kind_e   kind_q;
  logic [1:0] word_q;
  logic       wide_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      kind_q   <= RK_NONE;
      word_q   <= 2'd0;
      wide_q   <= 1'b0;
    end else begin
      rd_valid <= acc_valid && !acc_write;
      word_q   <= word;
      wide_q   <= wide;
      if (acc_valid && !acc_write)
        kind_q <= hit_table ? RK_TABLE : (hit_pend ? RK_PEND : RK_BAD);
      else
        kind_q <= RK_NONE;
    end
  end

  logic [31:0] sel32;
  always_comb begin
    case (word_q)
      2'd0:    sel32 = q_alo;
      2'd1:    sel32 = q_ahi;
      2'd2:    sel32 = q_dat;
      default: sel32 = q_vc;
    endcase
  end

  always_comb begin
    case (kind_q)
      RK_TABLE: rd_data = wide_q ? (word_q[1] ? {q_vc, q_dat} : {q_ahi, q_alo})
                                 : {32'h0, sel32};
      RK_PEND:  rd_data = 64'h0;
      default:  rd_data = '1;
    endcase
  end
endmodule

// File: rtl/irq_vector_table_chk.sv
module irq_vector_table_chk
  import ivt_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned OFF_W  = $clog2(pend_base(ENTRIES) + pend_bytes(ENTRIES)) + 1,
  localparam int unsigned IRQ_W  = $clog2(ENTRIES) + 1,
  localparam int unsigned PB     = pend_base(ENTRIES),
  localparam int unsigned PS     = pend_bytes(ENTRIES)
) (
  input logic             clk,
  input logic             rst,
  input logic             acc_valid,
  input logic             acc_write,
  input logic [3:0]       acc_bytes,
  input logic [OFF_W-1:0] acc_offset,
  input logic             rd_valid,
  input logic [63:0]      rd_data,
  input logic             cfg_enable,
  input logic             cfg_legacy_en,
  input logic             cfg_func_mask,
  input logic             irq_req,
  input logic [IRQ_W-1:0] irq_index,
  input logic             msg_valid
);
  logic pend_rd;
  assign pend_rd = acc_valid && !acc_write &&
                   ((acc_bytes == 4'd8 && acc_offset[2:0] == 3'b000) ||
                    (acc_bytes == 4'd4 && acc_offset[1:0] == 2'b00)) &&
                   (32'(acc_offset) >= PB) && (32'(acc_offset) < PB + PS);

  a_r8_read_latency: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write) |=> rd_valid);

  a_r8_no_spurious_read: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(acc_valid && !acc_write));

  a_r2_bad_size_ones: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write && acc_bytes != 4'd4 && acc_bytes != 4'd8) |=> (rd_data == '1));

  a_r5_pending_zero: assert property (@(posedge clk) disable iff (rst)
    pend_rd |=> (rd_data == 64'h0));

  a_r9_gated: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> $past(irq_req && cfg_enable && !cfg_legacy_en && !cfg_func_mask &&
                        32'(irq_index) < ENTRIES));

  a_r11_masked_dropped: assert property (@(posedge clk) disable iff (rst)
    (irq_req && cfg_func_mask) |=> !msg_valid);

  a_r10_no_request_no_msg: assert property (@(posedge clk) disable iff (rst)
    !irq_req |=> !msg_valid);
endmodule

bind irq_vector_table irq_vector_table_chk #(.ENTRIES(ENTRIES)) u_chk (.*);

// File: tb/tb_irq_vector_table.sv
module tb_irq_vector_table;
  localparam int N      = 16;
  localparam int PBA_OFF = ((N * 16 + 4095) / 4096) * 4096;
  localparam int PBA_B   = ((N - 1) / 64 + 1) * 8;
  localparam int OFF_W   = 14;
  localparam int IRQ_W   = 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             acc_valid = 1'b0, acc_write = 1'b0;
  logic [3:0]       acc_bytes = 4'd4;
  logic [OFF_W-1:0] acc_offset = '0;
  logic [63:0]      acc_wdata = '0;
  logic             rd_valid;
  logic [63:0]      rd_data;
  logic             cfg_enable = 1'b0, cfg_legacy_en = 1'b0, cfg_func_mask = 1'b0;
  logic             irq_req = 1'b0;
  logic [IRQ_W-1:0] irq_index = '0;
  logic             msg_valid;
  logic [7:0]       msg_dest, msg_vector;

  always #10 clk = ~clk;  // 50 MHz

  irq_vector_table #(.ENTRIES(N)) dut (.*);

  int checks = 0;
  int fails  = 0;
  string cur_req = "R6";

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic [31:0] m_alo [N];
  logic [31:0] m_ahi [N];
  logic [31:0] m_dat [N];
  logic [31:0] m_vc  [N];
  logic        ex_rv = 1'b0, ex_mv = 1'b0;
  logic [63:0] ex_rd = '0;
  logic [7:0]  ex_dest = '0, ex_vec = '0;

  function automatic logic [63:0] mread(input int b, input int off);
    int eo, e, w;
    logic [31:0] f [4];
    eo = off % 16; e = off / 16; w = eo / 4;
    if (b != 4 && b != 8) return '1;
    if (eo % b != 0) return '1;
    if (e < N) begin
      f[0] = m_alo[e]; f[1] = m_ahi[e]; f[2] = m_dat[e]; f[3] = m_vc[e];
      if (b == 4) return {32'h0, f[w]};
      return {f[w+1], f[w]};
    end
    if (off >= PBA_OFF && off < PBA_OFF + PBA_B) return 64'h0;
    return '1;
  endfunction

  task automatic mwrite(input int b, input int off, input logic [63:0] d);
    int eo, e, w;
    logic [31:0] f [4];
    eo = off % 16; e = off / 16; w = eo / 4;
    if ((b == 4 || b == 8) && (eo % b == 0) && e < N) begin
      f[0] = m_alo[e]; f[1] = m_ahi[e]; f[2] = m_dat[e]; f[3] = m_vc[e];
      f[w] = d[31:0];
      if (b == 8) f[w+1] = d[63:32];
      m_alo[e] = f[0]; m_ahi[e] = f[1]; m_dat[e] = f[2]; m_vc[e] = f[3];
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        m_vc[i] = 32'd1; m_alo[i] = '0; m_ahi[i] = '0; m_dat[i] = '0;
      end
      ex_rv = 1'b0; ex_mv = 1'b0;
    end else begin
      ex_rv = acc_valid && !acc_write;
      if (ex_rv) ex_rd = mread(int'(acc_bytes), int'(acc_offset));
      ex_mv = 1'b0;
      if (irq_req && cfg_enable && !cfg_legacy_en && !cfg_func_mask &&
          int'(irq_index) < N && m_vc[irq_index][0] == 1'b0) begin
        ex_mv   = 1'b1;
        ex_dest = m_alo[irq_index][19:12];
        ex_vec  = m_dat[irq_index][7:0];
      end
      if (acc_valid && acc_write) mwrite(int'(acc_bytes), int'(acc_offset), acc_wdata);
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(rd_valid === ex_rv, {cur_req, " rd_valid vs model (R8)"}, 64'(rd_valid), 64'(ex_rv));
      if (ex_rv) chk(rd_data === ex_rd, {cur_req, " rd_data vs model"}, rd_data, ex_rd);
      chk(msg_valid === ex_mv, {cur_req, " msg_valid vs model"}, 64'(msg_valid), 64'(ex_mv));
      if (ex_mv)
        chk({msg_dest, msg_vector} === {ex_dest, ex_vec}, {cur_req, " message vs model"},
            64'({msg_dest, msg_vector}), 64'({ex_dest, ex_vec}));
    end
  end

  // ---------------- stimulus helpers (called at a negedge) ----------------
  task automatic wr(input int b, input int off, input logic [63:0] d);
    acc_valid = 1'b1; acc_write = 1'b1; acc_bytes = 4'(b);
    acc_offset = OFF_W'(off); acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic rd_check(input int b, input int off, input logic [63:0] exp,
                          input string req);
    acc_valid = 1'b1; acc_write = 1'b0; acc_bytes = 4'(b); acc_offset = OFF_W'(off);
    @(negedge clk);
    acc_valid = 1'b0;
    chk(rd_valid === 1'b1 && rd_data === exp, req, rd_data, exp);
  endtask

  task automatic irq_check(input int idx, input bit exp_v, input logic [7:0] d,
                           input logic [7:0] v, input string req);
    irq_req = 1'b1; irq_index = IRQ_W'(idx);
    @(negedge clk);
    irq_req = 1'b0;
    chk(msg_valid === exp_v, req, 64'(msg_valid), 64'(exp_v));
    if (exp_v) chk({msg_dest, msg_vector} === {d, v}, req, 64'({msg_dest, msg_vector}),
                   64'({d, v}));
  endtask

  function automatic logic [31:0] alo_of(input int i);
    return 32'hFEE0_0000 | (32'(i + 3) << 12);
  endfunction
  function automatic logic [31:0] dat_of(input int i);
    return 32'h0000_4130 + 32'(i);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state
    chk(rd_valid === 1'b0 && msg_valid === 1'b0, "R6 outputs idle after reset",
        64'({rd_valid, msg_valid}), 64'h0);
    for (int i = 0; i < N; i++) rd_check(4, i * 16 + 12, 64'h1, "R6 control word masked");

    // fill: even descriptors by 8-byte, odd by 4-byte accesses
    cur_req = "R1";
    for (int i = 0; i < N; i++) begin
      if (i % 2 == 0) begin
        wr(8, i * 16, {32'(i * 3), alo_of(i)});
        wr(8, i * 16 + 8, {32'h1, dat_of(i)});
      end else begin
        wr(4, i * 16, {32'hDEAD_BEEF, alo_of(i)});
        wr(4, i * 16 + 4, 64'(i * 3));
        wr(4, i * 16 + 8, 64'(dat_of(i)));
      end
    end
    for (int i = 0; i < N; i++) begin
      rd_check(4, i * 16 + 8, {32'h0, dat_of(i)}, "R1 data word readback");
      rd_check(4, i * 16 + 4, 64'(i * 3), "R8 4-byte read upper zero");
      rd_check(8, i * 16, {32'(i * 3), alo_of(i)}, "R7 8-byte address pair");
    end
    rd_check(8, 3 * 16 + 8, {32'h1, dat_of(3)}, "R7 8-byte data and control");

    cur_req = "R2";
    wr(2, 16, 64'hFFFF);
    wr(1, 16, 64'hFF);
    rd_check(4, 16, {32'h0, alo_of(1)}, "R2 narrow writes ignored");
    rd_check(2, 16, '1, "R2 2-byte read all ones");
    rd_check(1, 17, '1, "R2 1-byte read all ones");
    rd_check(6, 16, '1, "R2 6-byte read all ones");

    cur_req = "R3";
    wr(8, 4 * 16 + 4, 64'h1111_2222_3333_4444);
    wr(4, 4 * 16 + 2, 64'h5555_6666);
    rd_check(8, 4 * 16, {32'(12), alo_of(4)}, "R3 misaligned writes ignored");
    rd_check(8, 4 * 16 + 4, '1, "R3 8-byte at offset 4 all ones");
    rd_check(4, 4 * 16 + 2, '1, "R3 4-byte at offset 2 all ones");

    cur_req = "R4";
    wr(4, N * 16, 64'h1234);
    wr(8, N * 16 + 8, 64'h0);
    rd_check(4, N * 16, '1, "R4 beyond count reads all ones");
    rd_check(8, N * 16 + 8, '1, "R4 beyond count 8-byte all ones");

    cur_req = "R5";
    wr(8, PBA_OFF, '1);
    rd_check(8, PBA_OFF, 64'h0, "R5 pending start reads zero");
    rd_check(4, PBA_OFF + PBA_B - 4, 64'h0, "R5 pending last word zero");
    rd_check(4, PBA_OFF + PBA_B, '1, "R5 past pending end all ones");
    rd_check(8, PBA_OFF - 8, '1, "R5 before pending start all ones");

    cur_req = "R9";
    wr(4, 2 * 16 + 12, 64'h0);  // unmask descriptor 2
    irq_check(2, 1'b0, 0, 0, "R9 blocked while disabled");
    cfg_enable = 1'b1; cfg_legacy_en = 1'b1;
    irq_check(2, 1'b0, 0, 0, "R9 blocked by legacy scheme");
    cfg_legacy_en = 1'b0; cfg_func_mask = 1'b1;
    irq_check(2, 1'b0, 0, 0, "R9 blocked by function mask");
    cfg_func_mask = 1'b0;
    cur_req = "R10";
    irq_check(2, 1'b1, 8'd5, dat_of(2)[7:0], "R10 message fields entry 2");
    irq_check(N, 1'b0, 0, 0, "R9 index at count blocked");
    irq_check(3, 1'b0, 0, 0, "R9 masked descriptor blocked");
    wr(8, 8, {32'h0, dat_of(0)});
    irq_check(0, 1'b1, 8'd3, dat_of(0)[7:0], "R10 message fields entry 0");

    cur_req = "R11";
    irq_check(5, 1'b0, 0, 0, "R11 request on masked entry");
    wr(4, 5 * 16 + 12, 64'h0);
    repeat (3) begin
      @(negedge clk);
      chk(msg_valid === 1'b0, "R11 no late message", 64'(msg_valid), 64'h0);
    end
    rd_check(8, PBA_OFF, 64'h0, "R11 pending stays zero");
    irq_check(5, 1'b1, 8'd8, dat_of(5)[7:0], "R11 fresh request delivered");

    // randomised traffic against the model
    cur_req = "R1/R9 random";
    for (int k = 0; k < 600; k++) begin
      int sel;
      sel = $urandom_range(0, 9);
      acc_valid  = ($urandom_range(0, 3) != 0);
      acc_write  = ($urandom_range(0, 2) == 0);
      acc_bytes  = 4'(1 << $urandom_range(0, 3));
      acc_offset = (sel == 0) ? OFF_W'(PBA_OFF - 8 + $urandom_range(0, 24))
                              : OFF_W'($urandom_range(0, N * 16 + 31));
      acc_wdata  = {$urandom, $urandom};
      irq_req    = $urandom_range(0, 1);
      irq_index  = IRQ_W'($urandom_range(0, N + 3));
      cfg_enable    = ($urandom_range(0, 7) != 0);
      cfg_legacy_en = ($urandom_range(0, 7) == 0);
      cfg_func_mask = ($urandom_range(0, 7) == 0);
      @(negedge clk);
    end
    acc_valid = 1'b0; irq_req = 1'b0;
    repeat (2) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule